// File: doc/BRIEF.md
# Host-Bus Sample Exchange Buffer

This block lets a host processor treat the sample-capture logic as an ordinary asynchronous SRAM on its parallel memory bus. The host drives an active-low chip select, read strobe, write strobe, a small word address and write data. The block decodes these and returns read data or takes write data. Two on-chip ring buffers sit behind the bus. The first collects converter samples that the capture side pushes. The host drains it one word per read of a fixed pop address. The second receives stimulus words that the host writes to a fixed push address. The output side pops them through a valid/ready pair.

The whole block runs on the host's master clock. Bus strobes are therefore sampled as ordinary synchronous inputs, with no edge detection across clock domains. A level interrupt tells the host when to start a DMA burst. It fires when the capture buffer has filled to a programmable mark, or when the stimulus buffer has drained below one. Sticky flags record words that were lost and reads that found the capture buffer empty.

The word addresses are: 0 levels, 1 flags, 2 marks, 3 interrupt enables, 4 capture pop, 5 stimulus push. Any other address reads as zero and ignores writes.

Top module: `sbuf_host_slave`

## Requirements
- R1: While reset is low and right after it, `bus_rdata`, `irq` and `stim_valid` are 0. Both buffers are empty. The flags are 0. The marks register reads 0x0008, which is half the default depth of 16.
- R2: Each read access of address 4 returns the oldest captured word, so words come back in push order. Each such access removes that word.
- R3: A read access is one stretch in which chip select and read strobe are both low. It removes at most one word from the capture buffer, however many clocks the strobe is held.
- R4: A capture push while the capture buffer holds DEPTH words is dropped and sets flag bit 0 of address 1. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R5: A read of address 4 when the capture buffer is empty returns 0. It sets flag bit 1 and does not change the level.
- R6: Each write access to address 5 appends `bus_wdata` to the stimulus buffer. `stim_valid` is high while that buffer is non-empty, and `stim_data` shows the oldest word. A clock with `stim_ready` high removes that word. A write while the buffer is full is dropped and sets flag bit 2.
- R7: Address 0 reads the capture level in bits [4:0] and the stimulus level in bits [12:8]. All other bits are 0.
- R8: When enable bit 0 is set and the capture level is at least the mark in bits [4:0] of address 2, `irq` is high from the next clock on. It falls one clock after the condition ends.
- R9: When enable bit 1 is set and the stimulus level is below the mark in bits [12:8] of address 2, `irq` is high from the next clock on. It falls one clock after the stimulus level reaches the mark.
- R10: A strobe made while chip select is high has no effect on any register or buffer.
- R11: Addresses 2 and 3 read back the values last written, in the field positions given in R8 and R9. Address 3 uses bits [1:0] only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data from host |
| bus_rdata | output | DATA_W | Read data, registered at the start of a read access and held |
| cap_valid | input | 1 | Capture side presents a sample this clock |
| cap_data | input | DATA_W | Captured sample |
| stim_ready | input | 1 | Stimulus side takes the head word this clock |
| stim_valid | output | 1 | Stimulus buffer is non-empty |
| stim_data | output | DATA_W | Oldest stimulus word |
| irq | output | 1 | Level interrupt for DMA service |

## Verification
A wrong pointer or level in either buffer shows up at the ports on the very next access. The next pop returns a word out of order or a stale one, and the next read of address 0 gives the wrong fill counts. A strobe that advances the pointer more than once makes a later read return a word that was skipped. A mistake in the interrupt comparison appears on `irq` one clock after the level or mark changes. The bench therefore checks `irq` right after every level crossing.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   // word addresses of the host-visible map
   localparam int unsigned ADR_LEVELS = 0;
   localparam int unsigned ADR_FLAGS  = 1;
   localparam int unsigned ADR_MARKS  = 2;
   localparam int unsigned ADR_ENABLE = 3;
   localparam int unsigned ADR_POP    = 4;
   localparam int unsigned ADR_PUSH   = 5;
   // flag bit positions
   localparam int unsigned FLG_CAP_LOST  = 0;
   localparam int unsigned FLG_CAP_EMPTY = 1;
   localparam int unsigned FLG_STIM_LOST = 2;
   // second field of the levels and marks words starts here
   localparam int unsigned HI_FIELD = 8;
endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PTR_W = CNT_W - 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             push_ok, pop_ok;

   assign full    = (level == CNT_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sbuf_bus_decode.sv
module sbuf_bus_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_start,
   output logic wr_start
);
   logic rd_act, wr_act, rd_act_q, wr_act_q;

   assign rd_act   = ~cs_n & ~rd_n;
   assign wr_act   = ~cs_n & ~wr_n;
   assign rd_start = rd_act & ~rd_act_q;
   assign wr_start = wr_act & ~wr_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act_q <= 1'b0;
         wr_act_q <= 1'b0;
      end else begin
         rd_act_q <= rd_act;
         wr_act_q <= wr_act;
      end
   end
endmodule

// File: rtl/sbuf_irq.sv
module sbuf_irq #(
   parameter int unsigned CNT_W   = 5,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       enable,
   input  logic [CNT_W-1:0] cap_level,
   input  logic [CNT_W-1:0] cap_mark,
   input  logic [CNT_W-1:0] stim_level,
   input  logic [CNT_W-1:0] stim_mark,
   output logic             irq
);
   logic cond;

   assign cond = (enable[0] & (cap_level >= cap_mark)) |
                 (enable[1] & (stim_level < stim_mark));

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= cond;
         end
      end else begin : g_comb
         assign irq = cond;
      end
   endgenerate
endmodule

// File: rtl/sbuf_host_slave.sv
module sbuf_host_slave
   import sbuf_pkg::*;
#(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DEPTH   = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cap_valid,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              stim_ready,
   output logic              stim_valid,
   output logic [DATA_W-1:0] stim_data,
   output logic              irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sbuf_host_slave: DEPTH must be a power of two, at least 2");
      end
      if (CNT_W > HI_FIELD) begin : g_bad_cnt
         $error("sbuf_host_slave: level field wider than its slot");
      end
      if (DATA_W < 2 * HI_FIELD) begin : g_bad_data
         $error("sbuf_host_slave: DATA_W must hold both level fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("sbuf_host_slave: ADDR_W too small for the map");
      end
   endgenerate

   logic              rd_start, wr_start;
   logic              sel_levels, sel_flags, sel_marks, sel_enable, sel_pop, sel_push;
   logic [CNT_W-1:0]  adc_level, dac_level;
   logic              cap_full, cap_empty, stim_full, stim_empty;
   logic [DATA_W-1:0] cap_head;
   logic              cap_pop, stim_push;
   logic              flag_adc_ovf, flag_adc_unf, flag_dac_ovf;
   logic [CNT_W-1:0]  thr_adc, thr_dac;
   logic [1:0]        ctrl_irq_en;
   logic [DATA_W-1:0] levels_word, flags_word, marks_word, enable_word;

   sbuf_bus_decode u_dec (
      .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
      .rd_start(rd_start), .wr_start(wr_start)
   );

   assign sel_levels = (bus_addr == ADDR_W'(ADR_LEVELS));
   assign sel_flags  = (bus_addr == ADDR_W'(ADR_FLAGS));
   assign sel_marks  = (bus_addr == ADDR_W'(ADR_MARKS));
   assign sel_enable = (bus_addr == ADDR_W'(ADR_ENABLE));
   assign sel_pop    = (bus_addr == ADDR_W'(ADR_POP));
   assign sel_push   = (bus_addr == ADDR_W'(ADR_PUSH));

   assign cap_pop   = rd_start & sel_pop;
   assign stim_push = wr_start & sel_push;

   sbuf_ring #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .push(cap_valid), .push_data(cap_data), .pop(cap_pop),
      .head(cap_head), .level(adc_level), .full(cap_full), .empty(cap_empty)
   );

   sbuf_ring #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_stim (
      .clk(clk), .rst_n(rst_n),
      .push(stim_push), .push_data(bus_wdata), .pop(stim_ready),
      .head(stim_data), .level(dac_level), .full(stim_full), .empty(stim_empty)
   );

   assign stim_valid = ~stim_empty;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_adc     <= CNT_W'(DEPTH / 2);
         thr_dac     <= '0;
         ctrl_irq_en <= '0;
      end else if (wr_start) begin
         if (sel_marks) begin
            thr_adc <= bus_wdata[CNT_W-1:0];
            thr_dac <= bus_wdata[HI_FIELD +: CNT_W];
         end
         if (sel_enable) ctrl_irq_en <= bus_wdata[1:0];
      end
   end

   // sticky flags: a set in the same clock as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_adc_ovf <= 1'b0;
         flag_adc_unf <= 1'b0;
         flag_dac_ovf <= 1'b0;
      end else begin
         flag_adc_ovf <= (flag_adc_ovf & ~(wr_start & sel_flags & bus_wdata[FLG_CAP_LOST]))
                         | (cap_valid & cap_full);
         flag_adc_unf <= (flag_adc_unf & ~(wr_start & sel_flags & bus_wdata[FLG_CAP_EMPTY]))
                         | (cap_pop & cap_empty);
         flag_dac_ovf <= (flag_dac_ovf & ~(wr_start & sel_flags & bus_wdata[FLG_STIM_LOST]))
                         | (stim_push & stim_full);
      end
   end

   always_comb begin
      levels_word = '0;
      levels_word[CNT_W-1:0]        = adc_level;
      levels_word[HI_FIELD +: CNT_W] = dac_level;
      flags_word = '0;
      flags_word[FLG_CAP_LOST]  = flag_adc_ovf;
      flags_word[FLG_CAP_EMPTY] = flag_adc_unf;
      flags_word[FLG_STIM_LOST] = flag_dac_ovf;
      marks_word = '0;
      marks_word[CNT_W-1:0]        = thr_adc;
      marks_word[HI_FIELD +: CNT_W] = thr_dac;
      enable_word = '0;
      enable_word[1:0] = ctrl_irq_en;
   end

   // read data is captured once at the start of an access and held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_start) begin
         unique case (1'b1)
            sel_levels: bus_rdata <= levels_word;
            sel_flags:  bus_rdata <= flags_word;
            sel_marks:  bus_rdata <= marks_word;
            sel_enable: bus_rdata <= enable_word;
            sel_pop:    bus_rdata <= cap_empty ? '0 : cap_head;
            default:    bus_rdata <= '0;
         endcase
      end
   end

   sbuf_irq #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .enable(ctrl_irq_en),
      .cap_level(adc_level), .cap_mark(thr_adc),
      .stim_level(dac_level), .stim_mark(thr_dac),
      .irq(irq)
   );
endmodule

// File: rtl/sbuf_host_slave_chk.sv
module sbuf_host_slave_chk #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned CNT_W   = 5,
   parameter bit          IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_cs_n,
   input logic              bus_rd_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cap_valid,
   input logic              stim_ready,
   input logic              irq,
   input logic [CNT_W-1:0]  adc_level,
   input logic [CNT_W-1:0]  dac_level,
   input logic              flag_adc_ovf,
   input logic              flag_adc_unf,
   input logic [1:0]        ctrl_irq_en,
   input logic [CNT_W-1:0]  thr_adc,
   input logic [CNT_W-1:0]  thr_dac
);
   logic rd_on, rd_on_q, at_pop, cap_hit, stim_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_on_q <= 1'b0;
      else        rd_on_q <= rd_on;
   end

   assign rd_on    = ~bus_cs_n & ~bus_rd_n;
   assign at_pop   = (bus_addr == ADDR_W'(4));
   assign cap_hit  = ctrl_irq_en[0] && (adc_level >= thr_adc);
   assign stim_hit = ctrl_irq_en[1] && (dac_level < thr_dac);

   // R2: occupancy never exceeds the ring size
   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_level <= CNT_W'(DEPTH)) && (dac_level <= CNT_W'(DEPTH)));

   // R3: a held read strobe does not remove further words
   a_r3_single_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && rd_on_q && at_pop && !cap_valid) |=> $stable(adc_level));

   // R4: a push into a full capture ring is lost and flagged
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_level == CNT_W'(DEPTH) && cap_valid && !(rd_on && !rd_on_q && at_pop))
      |=> (adc_level == CNT_W'(DEPTH)) && flag_adc_ovf);

   // R5: popping an empty ring returns zero and flags it
   a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && !rd_on_q && at_pop && adc_level == '0 && !cap_valid)
      |=> (bus_rdata == '0) && flag_adc_unf && (adc_level == '0));

   // R10: with chip select high and the side ports idle nothing moves
   a_r10_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n && !cap_valid && !stim_ready)
      |=> $stable(adc_level) && $stable(dac_level) && $stable(thr_adc) && $stable(thr_dac));

   generate
      if (IRQ_REG) begin : g_irq_reg
         // R8, R9: interrupt follows the level conditions one clock later
         a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_hit || stim_hit) |=> irq);
         a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (!cap_hit && !stim_hit) |=> !irq);
      end else begin : g_irq_comb
         a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_hit || stim_hit) |-> irq);
         a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (!cap_hit && !stim_hit) |-> !irq);
      end
   endgenerate
endmodule

bind sbuf_host_slave sbuf_host_slave_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cap_valid(cap_valid),
   .stim_ready(stim_ready), .irq(irq), .adc_level(adc_level), .dac_level(dac_level),
   .flag_adc_ovf(flag_adc_ovf), .flag_adc_unf(flag_adc_unf),
   .ctrl_irq_en(ctrl_irq_en), .thr_adc(thr_adc), .thr_dac(thr_dac)
);

// File: tb/sbuf_host_slave_tb.sv
`timescale 1ns/1ps
module sbuf_host_slave_tb_top;
   localparam int AW = 3;
   localparam int DW = 16;

   // op codes of the vector table
   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CAP = 3'd2, OP_DPOP = 3'd3,
                          OP_IRQ = 3'd4, OP_DVAL = 3'd5, OP_NOCS = 3'd6;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  addr;
      logic [2:0]  hold;
      logic [3:0]  req;
      logic [15:0] data;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 41;
   localparam vec_t VECS [NV] = '{
      '{OP_RD,   3'd0, 3'd1, 4'd1,  16'h0000, 16'h0000}, // R1 levels empty
      '{OP_RD,   3'd2, 3'd1, 4'd11, 16'h0000, 16'h0008}, // R11 reset marks
      '{OP_WR,   3'd3, 3'd1, 4'd11, 16'h0003, 16'h0000}, // R11 enable both
      '{OP_RD,   3'd3, 3'd1, 4'd11, 16'h0000, 16'h0003}, // R11
      '{OP_IRQ,  3'd0, 3'd1, 4'd8,  16'h0000, 16'h0000}, // R8 below mark
      '{OP_CAP,  3'd0, 3'd1, 4'd2,  16'h1111, 16'h0000}, // R2
      '{OP_CAP,  3'd0, 3'd1, 4'd2,  16'h2222, 16'h0000}, // R2
      '{OP_CAP,  3'd0, 3'd1, 4'd2,  16'h3333, 16'h0000}, // R2
      '{OP_RD,   3'd0, 3'd1, 4'd7,  16'h0000, 16'h0003}, // R7
      '{OP_RD,   3'd4, 3'd1, 4'd2,  16'h0000, 16'h1111}, // R2 oldest first
      '{OP_RD,   3'd4, 3'd1, 4'd2,  16'h0000, 16'h2222}, // R2
      '{OP_RD,   3'd0, 3'd1, 4'd7,  16'h0000, 16'h0001}, // R7
      '{OP_WR,   3'd2, 3'd1, 4'd8,  16'h0001, 16'h0000}, // R8 mark 1
      '{OP_IRQ,  3'd0, 3'd1, 4'd8,  16'h0000, 16'h0001}, // R8 raised
      '{OP_RD,   3'd4, 3'd1, 4'd2,  16'h0000, 16'h3333}, // R2
      '{OP_IRQ,  3'd0, 3'd1, 4'd8,  16'h0000, 16'h0000}, // R8 dropped
      '{OP_RD,   3'd4, 3'd1, 4'd5,  16'h0000, 16'h0000}, // R5 empty pop
      '{OP_RD,   3'd1, 3'd1, 4'd5,  16'h0000, 16'h0002}, // R5 flag bit1
      '{OP_RD,   3'd0, 3'd1, 4'd5,  16'h0000, 16'h0000}, // R5 level kept
      '{OP_WR,   3'd1, 3'd1, 4'd5,  16'h0002, 16'h0000}, // R5 clear
      '{OP_RD,   3'd1, 3'd1, 4'd5,  16'h0000, 16'h0000}, // R5
      '{OP_WR,   3'd5, 3'd1, 4'd6,  16'hA0A0, 16'h0000}, // R6
      '{OP_WR,   3'd5, 3'd1, 4'd6,  16'hB0B0, 16'h0000}, // R6
      '{OP_RD,   3'd0, 3'd1, 4'd7,  16'h0000, 16'h0200}, // R7 stim level
      '{OP_WR,   3'd2, 3'd1, 4'd9,  16'h0308, 16'h0000}, // R9 stim mark 3
      '{OP_IRQ,  3'd0, 3'd1, 4'd9,  16'h0000, 16'h0001}, // R9 raised
      '{OP_DVAL, 3'd0, 3'd1, 4'd6,  16'h0000, 16'h0001}, // R6
      '{OP_DPOP, 3'd0, 3'd1, 4'd6,  16'h0000, 16'hA0A0}, // R6
      '{OP_DPOP, 3'd0, 3'd1, 4'd6,  16'h0000, 16'hB0B0}, // R6
      '{OP_DVAL, 3'd0, 3'd1, 4'd6,  16'h0000, 16'h0000}, // R6 drained
      '{OP_WR,   3'd5, 3'd1, 4'd6,  16'h0001, 16'h0000}, // R6
      '{OP_WR,   3'd5, 3'd1, 4'd6,  16'h0002, 16'h0000}, // R6
      '{OP_WR,   3'd5, 3'd1, 4'd6,  16'h0003, 16'h0000}, // R6
      '{OP_IRQ,  3'd0, 3'd1, 4'd9,  16'h0000, 16'h0000}, // R9 dropped
      '{OP_NOCS, 3'd5, 3'd1, 4'd10, 16'h0009, 16'h0000}, // R10
      '{OP_RD,   3'd0, 3'd1, 4'd10, 16'h0000, 16'h0300}, // R10 unchanged
      '{OP_CAP,  3'd0, 3'd1, 4'd3,  16'h4444, 16'h0000}, // R3
      '{OP_CAP,  3'd0, 3'd1, 4'd3,  16'h5555, 16'h0000}, // R3
      '{OP_RD,   3'd4, 3'd4, 4'd3,  16'h0000, 16'h4444}, // R3 long strobe
      '{OP_RD,   3'd4, 3'd1, 4'd3,  16'h0000, 16'h5555}, // R3 next word
      '{OP_RD,   3'd0, 3'd1, 4'd3,  16'h0000, 16'h0300}  // R3 levels
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          cap_valid = 1'b0;
   logic [DW-1:0] cap_data = '0;
   logic          stim_ready = 1'b0;
   logic          stim_valid;
   logic [DW-1:0] stim_data;
   logic          irq;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   sbuf_host_slave dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cap_valid(cap_valid), .cap_data(cap_data),
      .stim_ready(stim_ready), .stim_valid(stim_valid), .stim_data(stim_data), .irq(irq)
   );

   task automatic chk(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                      input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit sel);
      @(negedge clk);
      bus_cs_n = ~sel; bus_wr_n = 1'b0; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_cs_n = 1'b1; bus_wr_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input int hold, output logic [DW-1:0] d);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_addr = a;
      repeat (hold) @(posedge clk);
      @(negedge clk);
      d = bus_rdata;
      bus_cs_n = 1'b1; bus_rd_n = 1'b1;
   endtask

   task automatic cap_push(input logic [DW-1:0] d);
      @(negedge clk);
      cap_valid = 1'b1; cap_data = d;
      @(posedge clk);
      @(negedge clk);
      cap_valid = 1'b0;
   endtask

   task automatic stim_pop(input int req, input logic [DW-1:0] exp);
      @(negedge clk);
      chk(req, stim_data, exp, "stimulus head");
      stim_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      stim_ready = 1'b0;
   endtask

   task automatic rd_chk(input int req, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input string what);
      logic [DW-1:0] d;
      bus_rd(a, 1, d);
      chk(req, d, exp, what);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      // R1 outputs while held in reset
      chk(1, bus_rdata, '0, "rdata in reset");
      chk(1, {15'd0, irq}, 16'd0, "irq in reset");
      chk(1, {15'd0, stim_valid}, 16'd0, "stim_valid in reset");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         case (v.op)
            OP_WR:   bus_wr(v.addr, v.data, 1'b1);
            OP_NOCS: bus_wr(v.addr, v.data, 1'b0);
            OP_RD: begin
               bus_rd(v.addr, int'(v.hold), d);
               chk(int'(v.req), d, v.exp, $sformatf("vector %0d read", i));
            end
            OP_CAP:  cap_push(v.data);
            OP_DPOP: stim_pop(int'(v.req), v.exp);
            OP_IRQ: begin
               @(negedge clk);
               chk(int'(v.req), {15'd0, irq}, v.exp, $sformatf("vector %0d irq", i));
            end
            OP_DVAL: begin
               @(negedge clk);
               chk(int'(v.req), {15'd0, stim_valid}, v.exp, $sformatf("vector %0d valid", i));
            end
            default: ;
         endcase
      end

      // R4: fill the capture ring past capacity (mark is 8, enable bit 0 set)
      for (int k = 0; k < 17; k++) cap_push(16'(k));
      @(negedge clk);
      chk(8, {15'd0, irq}, 16'd1, "irq with full capture ring");
      rd_chk(4, 3'd1, 16'h0001, "overflow flag");
      rd_chk(4, 3'd0, 16'h0310, "levels at full");
      for (int k = 0; k < 16; k++) rd_chk(4, 3'd4, 16'(k), "kept word");
      rd_chk(4, 3'd1, 16'h0001, "overflow flag stays sticky");
      bus_wr(3'd1, 16'h0000, 1'b1);
      rd_chk(4, 3'd1, 16'h0001, "writing 0 leaves flag");
      bus_wr(3'd1, 16'h0001, 1'b1);
      rd_chk(4, 3'd1, 16'h0000, "flag cleared by 1");

      // R6: stimulus ring overflow (holds 3 words now)
      for (int k = 0; k < 13; k++) bus_wr(3'd5, 16'h0100 + 16'(k), 1'b1);
      bus_wr(3'd5, 16'hDEAD, 1'b1);
      rd_chk(6, 3'd1, 16'h0004, "stimulus lost flag");
      rd_chk(6, 3'd0, 16'h1000, "stimulus level at full");
      stim_pop(6, 16'h0001);
      stim_pop(6, 16'h0002);
      stim_pop(6, 16'h0003);
      stim_pop(6, 16'h0100);

      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(1, bus_rdata, '0, "rdata after reset");
      chk(1, {15'd0, irq}, 16'd0, "irq after reset");
      chk(1, {15'd0, stim_valid}, 16'd0, "stim_valid after reset");
      rst_n = 1'b1;
      rd_chk(1, 3'd0, 16'h0000, "levels after reset");
      rd_chk(1, 3'd1, 16'h0000, "flags after reset");
      rd_chk(1, 3'd2, 16'h0008, "marks after reset");
      rd_chk(11, 3'd3, 16'h0000, "enables after reset");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule